// File: doc/BRIEF.md
# Cascadable Event Counter with Power-Mode Gating

This block counts rising edges on two external event lines with two 8-bit counter halves, a low half and a high half. Software picks, through a small register port, whether the halves run as two independent 8-bit counters or as one 16-bit counter. In 16-bit mode the low half counts and carries into the high half. Each half has its own enable bit and its own sticky overflow flag. Each event line goes through a two-flop synchronizer and a rising-edge detector in the system clock domain. An event line is sampled reliably when its high and low levels each last at least one system clock period.

A 3-bit power-mode input and a source-select bit decide what keeps running. In active mode the counters run normally. In the lighter low-power modes the counters keep running only when the event lines are declared asynchronous sources. In two of those modes the counters advance but the overflow flags stay quiet. In module standby everything freezes, and register writes have no effect.

The block has no streaming data path. The register port is a plain single-cycle write strobe with a combinational read mux. It has no valid/ready handshake and no back-pressure: every write is accepted in the cycle it is presented, unless module standby blocks it.

Top module: `evt_counter_top`

## Requirements
- R1: After reset, all four registers read 0 and both overflow outputs are 0.
- R2: A rising edge on an event line adds exactly one to the half it feeds. The new count is readable after the third rising clock edge following the input change: two synchronizer stages, then the count register.
- R3: With the chain bit (control bit 2) at 0, the low half counts `evt_lo` when control bit 0 is set, and the high half counts `evt_hi` when control bit 1 is set. The halves are independent, and each wraps from 0xFF to 0x00.
- R4: With control bit 2 at 1, the low half counts `evt_lo` gated by control bit 0 alone. The high half increments once, in the same cycle that the low half wraps from 0xFF to 0x00. In this mode `evt_hi` and control bit 1 have no effect, and clearing control bit 0 freezes the full 16-bit value.
- R5: A half that wraps sets its overflow flag: status bit 0 for the low half, status bit 1 for the high half, also driven on `ovf_lo`/`ovf_hi`. The flag stays set until software writes 0 to that bit. Writing 1 has no effect, and a clear wins over a set in the same cycle.
- R6: A write to a count register wins over an increment of that half in the same cycle. In 16-bit mode, a low half that is being written passes no carry and sets no flag.
- R7: In power modes 1 to 5 (1 sleep, 2 watch, 3 subactive, 4 subsleep, 5 standby), the counters hold their value when `src_async` is 0 and keep counting when `src_async` is 1. Mode 0 (active) always counts.
- R8: In modes 2 and 5, counting continues with `src_async` at 1, but neither overflow flag is set.
- R9: In mode 6 (module standby) and in the unused code 7, both halves are halted, register writes are ignored, and all registers keep their values.
- R10: Register map on `reg_addr`: 0 control (bit 0 low enable, bit 1 high enable, bit 2 chain), 1 status (bit 0 low overflow, bit 1 high overflow), 2 low count, 3 high count. Reads are combinational, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_lo | input | 1 | Event line feeding the low half |
| evt_hi | input | 1 | Event line feeding the high half (8-bit mode only) |
| pwr_mode | input | 3 | Power mode code, 0 to 6 as listed in R7 and R9 |
| src_async | input | 1 | 1: event lines are asynchronous sources that keep counting in low-power modes |
| ovf_lo | output | 1 | Low-half overflow flag |
| ovf_hi | output | 1 | High-half overflow flag |

## Verification
The timing of each result is fixed:
- An event line that changes just after a clock edge shows up in the count after the third rising edge.
- A register write lands on the next rising edge.
- An overflow flag changes on the same edge as the wrap that sets it.
- Read data follows `reg_addr` with no clock delay.

The bench drives inputs at falling edges. It holds each event level for three full cycles so that every increment has landed before the next stimulus. It samples only at falling edges or shortly after an address change. For the tests that pair a write with an increment, it raises the event line and places the write two falling edges later, so both fall on the same rising edge.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE   = 3'd0,
    PM_SLEEP    = 3'd1,
    PM_WATCH    = 3'd2,
    PM_SUBACT   = 3'd3,
    PM_SUBSLEEP = 3'd4,
    PM_STANDBY  = 3'd5,
    PM_MSTBY    = 3'd6,
    PM_RSVD     = 3'd7
  } pmode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CLO  = 2'd2;
  localparam logic [1:0] ADDR_CHI  = 2'd3;

  localparam int CTRL_EN_LO = 0;
  localparam int CTRL_EN_HI = 1;
  localparam int CTRL_CHAIN = 2;
  localparam int CTRL_BITS  = 3;

  localparam int NUM_HALVES = 2;

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[LAST-1:0], async_in};
  end

  assign rise = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/evt_pwr_gate.sv
module evt_pwr_gate
  import evt_ctr_pkg::*;
(
  input  logic [2:0] pwr_mode,
  input  logic       src_async,
  output logic       run_ok,
  output logic       flag_ok,
  output logic       wr_ok
);
  pmode_e mode;
  assign mode = pmode_e'(pwr_mode);

  always_comb begin
    run_ok  = 1'b0;
    flag_ok = 1'b0;
    wr_ok   = 1'b1;
    unique case (mode)
      PM_ACTIVE: begin
        run_ok  = 1'b1;
        flag_ok = 1'b1;
      end
      PM_SLEEP, PM_SUBACT, PM_SUBSLEEP: begin
        run_ok  = src_async;
        flag_ok = 1'b1;
      end
      PM_WATCH, PM_STANDBY: begin
        run_ok  = src_async;
        flag_ok = 1'b0;
      end
      default: begin
        run_ok  = 1'b0;
        flag_ok = 1'b0;
        wr_ok   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/evt_ctr_half.sv
module evt_ctr_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= cnt + ONE;
  end

  // a load cancels the increment, so a loaded half never wraps
  assign wrap = inc & ~ld & (cnt == ALL_ONES);
endmodule

// File: rtl/evt_counter_top.sv
module evt_counter_top
  import evt_ctr_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  input  logic              evt_lo,
  input  logic              evt_hi,
  input  logic [2:0]        pwr_mode,
  input  logic              src_async,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  localparam int CTRL_PAD = HALF_W - CTRL_BITS;
  localparam int STAT_PAD = HALF_W - NUM_HALVES;

  logic run_ok, flag_ok, wr_ok;
  logic en_lo, en_hi, cascade;
  logic [NUM_HALVES-1:0] evt_in, rise, inc, ld, wrap, ovf_q;
  logic [HALF_W-1:0]     cnt [NUM_HALVES];
  logic [HALF_W-1:0]     cnt_lo, cnt_hi;
  logic                  wr_ctrl, wr_stat;

  assign evt_in = {evt_hi, evt_lo};

  evt_pwr_gate u_pwr (
    .pwr_mode (pwr_mode),
    .src_async(src_async),
    .run_ok   (run_ok),
    .flag_ok  (flag_ok),
    .wr_ok    (wr_ok)
  );

  assign wr_ctrl = reg_wr & wr_ok & (reg_addr == ADDR_CTRL);
  assign wr_stat = reg_wr & wr_ok & (reg_addr == ADDR_STAT);
  assign ld[0]   = reg_wr & wr_ok & (reg_addr == ADDR_CLO);
  assign ld[1]   = reg_wr & wr_ok & (reg_addr == ADDR_CHI);

  // low half: own event, own enable
  assign inc[0] = rise[0] & en_lo & run_ok;
  // high half: carry in chained mode, own event otherwise
  assign inc[1] = cascade ? wrap[0] : (rise[1] & en_hi & run_ok);

  for (genvar i = 0; i < NUM_HALVES; i++) begin : g_half
    evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(evt_in[i]),
      .rise    (rise[i])
    );

    evt_ctr_half #(.W(HALF_W)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld[i]),
      .ld_val(reg_wdata),
      .inc   (inc[i]),
      .cnt   (cnt[i]),
      .wrap  (wrap[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ovf_q[i] <= 1'b0;
      else if (wr_stat && !reg_wdata[i]) ovf_q[i] <= 1'b0;
      else if (wrap[i] && flag_ok)       ovf_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lo   <= 1'b0;
      en_hi   <= 1'b0;
      cascade <= 1'b0;
    end else if (wr_ctrl) begin
      en_lo   <= reg_wdata[CTRL_EN_LO];
      en_hi   <= reg_wdata[CTRL_EN_HI];
      cascade <= reg_wdata[CTRL_CHAIN];
    end
  end

  assign cnt_lo = cnt[0];
  assign cnt_hi = cnt[1];
  assign ovf_lo = ovf_q[0];
  assign ovf_hi = ovf_q[1];

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = {{CTRL_PAD{1'b0}}, cascade, en_hi, en_lo};
      ADDR_STAT: reg_rdata = {{STAT_PAD{1'b0}}, ovf_q};
      ADDR_CLO:  reg_rdata = cnt_lo;
      default:   reg_rdata = cnt_hi;
    endcase
  end
endmodule

// File: rtl/evt_counter_sva.sv
module evt_counter_sva #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   pwr_mode,
  input logic         src_async,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic         cascade,
  input logic         en_lo,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         ovf_lo,
  input logic         ovf_hi
);
  logic cnt_wr, hi_wr, lo_wr, quiet_mode, halt_mode, lp_mode;
  assign cnt_wr     = reg_wr & reg_addr[1];
  assign hi_wr      = reg_wr & (reg_addr == 2'd3);
  assign lo_wr      = reg_wr & (reg_addr == 2'd2);
  assign quiet_mode = (pwr_mode == 3'd2) || (pwr_mode == 3'd5);
  assign halt_mode  = pwr_mode[2] & pwr_mode[1];
  assign lp_mode    = (pwr_mode != 3'd0) && !halt_mode;

  AST_MSTBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halt_mode |=> ($stable(cnt_lo) && $stable(cnt_hi) && $stable(ovf_lo) &&
                   $stable(ovf_hi) && $stable(cascade) && $stable(en_lo))); // R9

  AST_SYNC_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && !src_async && !cnt_wr) |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R7

  AST_QUIET_FLAG_LO: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_mode |=> !$rose(ovf_lo)); // R8

  AST_QUIET_FLAG_HI: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_mode |=> !$rose(ovf_hi)); // R8

  AST_CHAIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !cnt_wr) |=> ((cnt_hi == $past(cnt_hi)) ||
      ($past(cnt_lo) == {W{1'b1}} && cnt_lo == '0))); // R4

  AST_CHAIN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !en_lo && !cnt_wr) |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R4

  AST_LO_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_wr |=> ((cnt_lo == $past(cnt_lo)) || (cnt_lo == W'($past(cnt_lo) + 1'b1)))); // R2

  AST_HI_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> ((cnt_hi == $past(cnt_hi)) || (cnt_hi == W'($past(cnt_hi) + 1'b1)))); // R3
endmodule

bind evt_counter_top evt_counter_sva #(.W(HALF_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_mode (pwr_mode),
  .src_async(src_async),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .cascade  (cascade),
  .en_lo    (en_lo),
  .cnt_lo   (cnt_lo),
  .cnt_hi   (cnt_hi),
  .ovf_lo   (ovf_lo),
  .ovf_hi   (ovf_hi)
);

// File: tb/evt_counter_tb.sv
module evt_counter_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       evt_lo = 1'b0;
  logic       evt_hi = 1'b0;
  logic [2:0] pwr_mode = 3'd0;
  logic       src_async = 1'b0;
  logic       ovf_lo, ovf_hi;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  evt_counter_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_lo(evt_lo),
    .evt_hi(evt_hi), .pwr_mode(pwr_mode), .src_async(src_async),
    .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic l, input logic h);
    @(negedge clk);
    evt_lo = l; evt_hi = h;
    repeat (3) @(negedge clk);
    evt_lo = 1'b0; evt_hi = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // low-half event whose increment edge coincides with a register write
  task automatic pulse_with_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    evt_lo = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; evt_lo = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v, lo, hi;
    int n_lo, n_hi;
    int base;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk($sformatf("R1 reset reg %0d", a), {8'd0, v}, 16'd0);
    end
    chk("R1 reset ovf outputs", {14'd0, ovf_hi, ovf_lo}, 16'd0);

    // R10 control readback, unused bits zero
    wr(2'd0, 8'hFF);
    rd(2'd0, v);
    chk("R10 control readback", {8'd0, v}, 16'h0007);
    wr(2'd0, 8'h03);

    // R2 latency: count lands on the third rising edge
    @(negedge clk); evt_lo = 1'b1;
    @(negedge clk);
    @(negedge clk); rd(2'd2, v); chk("R2 no count after two edges", {8'd0, v}, 16'd0);
    @(negedge clk); rd(2'd2, v); chk("R2 count after three edges", {8'd0, v}, 16'd1);
    evt_lo = 1'b0;
    repeat (3) @(negedge clk);

    // R3 8-bit sweep, independent halves, wrap
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    n_lo = 0; n_hi = 0;
    for (int i = 0; i < 300; i++) begin
      pulse(1'b1, (i % 3) == 0);
      n_lo++;
      if ((i % 3) == 0) n_hi++;
      rd(2'd2, lo); rd(2'd3, hi);
      chk($sformatf("R3 low half step %0d", i), {8'd0, lo}, 16'(n_lo % 256));
      chk($sformatf("R3 high half step %0d", i), {8'd0, hi}, 16'(n_hi % 256));
    end
    // R5 low wrapped (300 events), high did not (100 events)
    rd(2'd1, v);
    chk("R5 sticky low flag after wrap", {8'd0, v}, 16'h0001);
    chk("R5 ovf outputs", {14'd0, ovf_hi, ovf_lo}, 16'h0001);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R5 write 1 keeps flag", {8'd0, v}, 16'h0001);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R5 write 0 clears flag", {8'd0, v}, 16'h0000);

    // R3 per-half enable
    wr(2'd0, 8'h01);
    rd(2'd3, hi);
    pulse(1'b1, 1'b1);
    rd(2'd3, v); chk("R3 disabled high holds", {8'd0, v}, {8'd0, hi});

    // R4 16-bit sweep through FFFF, evt_hi and high enable ignored
    wr(2'd0, 8'h05);
    wr(2'd2, 8'hF0); wr(2'd3, 8'hFE);
    base = 16'hFEF0;
    for (int i = 1; i <= 300; i++) begin
      pulse(1'b1, 1'b1);
      rd(2'd2, lo); rd(2'd3, hi);
      chk($sformatf("R4 chained value step %0d", i), {hi, lo}, 16'((base + i) % 65536));
    end
    rd(2'd1, v); chk("R5 both flags after 16-bit wrap", {8'd0, v}, 16'h0003);
    wr(2'd1, 8'h00);

    // R4 low enable cleared freezes whole count
    wr(2'd0, 8'h06);
    rd(2'd2, lo); rd(2'd3, hi);
    pulse(1'b1, 1'b1);
    rd(2'd2, v);  chk("R4 freeze low", {8'd0, v}, {8'd0, lo});
    rd(2'd3, v);  chk("R4 freeze high", {8'd0, v}, {8'd0, hi});

    // R6 write beats increment, 8-bit
    wr(2'd0, 8'h03); wr(2'd2, 8'h20);
    pulse_with_write(2'd2, 8'h40);
    rd(2'd2, v); chk("R6 write wins over increment", {8'd0, v}, 16'h0040);

    // R6 chained: written low passes no carry, no flag
    wr(2'd0, 8'h05); wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF); wr(2'd3, 8'h20);
    pulse_with_write(2'd2, 8'h10);
    rd(2'd2, lo); rd(2'd3, hi);
    chk("R6 chained written low blocks carry", {hi, lo}, 16'h2010);
    rd(2'd1, v); chk("R6 no flag from written low", {8'd0, v}, 16'h0000);

    // R5 clear wins over set in the same cycle
    wr(2'd0, 8'h03); wr(2'd2, 8'hFF);
    pulse_with_write(2'd1, 8'h00);
    rd(2'd2, v); chk("R5 wrap while clearing", {8'd0, v}, 16'h0000);
    rd(2'd1, v); chk("R5 clear wins over set", {8'd0, v}, 16'h0000);

    // R7 R8 R9 power-mode sweep
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 2; a++) begin
        logic run, fl, wok;
        pwr_mode = 3'd0; src_async = 1'b0;
        wr(2'd0, 8'h03); wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        @(negedge clk);
        pwr_mode = 3'(m); src_async = a[0];
        run = (m == 0) || (m < 6 && a == 1);
        fl  = run && !(m == 2 || m == 5);
        wok = (m < 6);
        pulse(1'b1, 1'b1);
        rd(2'd2, lo); rd(2'd3, hi);
        chk($sformatf("R7 mode %0d async %0d count", m, a), {hi, lo},
            run ? 16'h0000 : 16'hFFFF);
        rd(2'd1, v);
        chk($sformatf("R8 mode %0d async %0d flags", m, a), {8'd0, v},
            fl ? 16'h0003 : 16'h0000);
        wr(2'd2, 8'h55);
        rd(2'd2, v);
        chk($sformatf("R9 mode %0d async %0d write", m, a), {8'd0, v},
            wok ? 16'h0055 : {8'd0, lo});
        rd(2'd0, v);
        chk($sformatf("R9 mode %0d control kept", m), {8'd0, v}, 16'h0003);
      end
    end
    pwr_mode = 3'd0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule